// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides, frame by frame, whether a received Ethernet frame should be kept or thrown away, judging only its 48-bit destination address. Bytes arrive one per accepted beat on a plain byte stream qualified by `in_valid`, with `in_sof` marking the first byte of a frame and `in_last` the final one. The first six bytes of every frame form the destination address, sent most significant byte first. The stream has no ready signal. The filter never stalls the source: every beat with `in_valid` high is consumed in the cycle it is presented, and idle cycles simply leave the address walk where it was.

The address table has eight entries. Entry 0 is meant for the station's own unicast address and entries 1 to 7 are meant for multicast groups. The table is stored byte-sliced: one 64-bit register per address byte position, each holding that byte for all eight entries. A control word selects the entries that take part, whether a table hit means keep or discard, whether broadcast frames are kept, and one of three multicast policies. Promiscuous reception is made from these: reject-on-hit polarity, no entries enabled, multicast accept-all and broadcast on. When there are more multicast groups than free entries, software enables only entry 0 and selects multicast accept-all.

The verdict appears as a one-cycle pulse on `dec_valid`, with `dec_accept` carrying keep (1) or discard (0).

Top module: `eth_dst_filter`

## Requirements
- R1: Configuration writes (`cfg_we` high) to `cfg_addr` 0..5 load the table register for address byte k = `cfg_addr`. Byte k of entry n sits in bits [8n+7:8n], and byte 0 is the first byte received. Entry n hits only when all six received bytes equal its six stored bytes. A write to `cfg_addr` 7 changes nothing.
- R2: The control word at `cfg_addr` 6 holds the entry enable mask in bits [7:0]. An entry whose enable bit is 0 never produces a hit, even if its stored bytes match.
- R3: Control bit 9 sets the hit polarity. With 1, a unicast frame is kept only if it hits an enabled entry. With 0, a hit discards the frame and a miss keeps it.
- R4: An address of all ones (broadcast) is kept if and only if control bit 8 is 1. Neither the table nor the multicast policy affects it.
- R5: A non-broadcast address whose first byte has bit 0 set is multicast, and control bits [11:10] choose its policy: 0 discard, 1 keep, 2 follow the table result under the R3 polarity, 3 discard. This policy does not affect unicast frames.
- R6: With polarity 0, enable mask 0, multicast policy 1 and broadcast bit 1, every frame is kept.
- R7: Exactly one verdict pulse is issued for each frame of six or more bytes. It appears in the cycle after the sixth byte is taken. Later bytes of the frame produce no pulse, and bytes with `in_valid` high outside a frame are ignored.
- R8: A frame whose `in_last` beat comes before its sixth byte gets a discard verdict in the cycle after that beat.
- R9: The configuration is captured at each start-of-frame beat. Writes made in that cycle or later in the frame take effect from the next start-of-frame.
- R10: After reset, all configuration is zero and `dec_valid` and `dec_accept` are 0. With this configuration unicast frames are kept, and multicast and broadcast frames are discarded.
- R11: Cycles with `in_valid` low do not advance the address walk. A frame sent with idle gaps gets the same verdict, one cycle after its sixth byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Register select: 0..5 table bytes, 6 control |
| cfg_wdata | input | 64 | Write data |
| in_valid | input | 1 | Byte present on `in_data` |
| in_sof | input | 1 | First byte of a frame |
| in_last | input | 1 | Final byte of a frame |
| in_data | input | 8 | Received byte |
| dec_valid | output | 1 | One-cycle verdict pulse |
| dec_accept | output | 1 | Verdict: 1 keep, 0 discard |

## Verification
A fixed table holding one unicast and two multicast entries, one of them disabled, is exercised with a set of addresses. Each address differs from a stored one in a different place: the first byte, the last byte, an entry that is disabled, an entry that is unprogrammed, or the broadcast pattern. This shows that every byte lane is compared and that the mask is obeyed. The same addresses are then replayed with other polarity, multicast-policy and broadcast settings, which separates the policy decoding from the table compare and confirms the promiscuous combination. Short frames, frames with idle gaps, stray bytes outside a frame and control writes timed within a frame show the timing of the verdict and the capture of the configuration at start-of-frame.

// File: rtl/eaf_pkg.sv
package eaf_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int BYTE_W     = 8;
  localparam int IDX_W      = $clog2(ADDR_BYTES + 1);
  localparam int CFG_AW     = 3;
  localparam logic [CFG_AW-1:0] CTRL_SLOT = CFG_AW'(ADDR_BYTES);

  typedef enum logic [1:0] {
    MC_REJECT = 2'd0,
    MC_ACCEPT = 2'd1,
    MC_TABLE  = 2'd2,
    MC_RSVD   = 2'd3
  } mc_mode_e;
endpackage

// File: rtl/eaf_cfg_regs.sv
module eaf_cfg_regs
  import eaf_pkg::*;
#(
  parameter int N_ENT = 8
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    we,
  input  logic [CFG_AW-1:0]                       addr,
  input  logic [BYTE_W*N_ENT-1:0]                 wdata,
  input  logic                                    capture,
  output logic [ADDR_BYTES-1:0][BYTE_W*N_ENT-1:0] eff_lanes,
  output logic [N_ENT-1:0]                        eff_en,
  output logic                                    eff_bc_ok,
  output logic                                    eff_hit_keep,
  output mc_mode_e                                eff_mc_mode
);
  localparam int LANE_W = BYTE_W * N_ENT;
  localparam int BC_BIT = N_ENT;
  localparam int PL_BIT = N_ENT + 1;
  localparam int MC_LSB = N_ENT + 2;

  logic [ADDR_BYTES-1:0][LANE_W-1:0] live_lanes, snap_lanes;
  logic [N_ENT-1:0] live_en, snap_en;
  logic             live_bc, snap_bc;
  logic             live_pl, snap_pl;
  mc_mode_e         live_mc, snap_mc;

  for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        live_lanes[k] <= '0;
        snap_lanes[k] <= '0;
      end else begin
        if (we && addr == CFG_AW'(k)) live_lanes[k] <= wdata;
        if (capture) snap_lanes[k] <= live_lanes[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_en <= '0;
      live_bc <= 1'b0;
      live_pl <= 1'b0;
      live_mc <= MC_REJECT;
      snap_en <= '0;
      snap_bc <= 1'b0;
      snap_pl <= 1'b0;
      snap_mc <= MC_REJECT;
    end else begin
      if (we && addr == CTRL_SLOT) begin
        live_en <= wdata[N_ENT-1:0];
        live_bc <= wdata[BC_BIT];
        live_pl <= wdata[PL_BIT];
        live_mc <= mc_mode_e'(wdata[MC_LSB+1:MC_LSB]);
      end
      if (capture) begin
        snap_en <= live_en;
        snap_bc <= live_bc;
        snap_pl <= live_pl;
        snap_mc <= live_mc;
      end
    end
  end

  // On the start beat the register values are used directly; afterwards the copy.
  always_comb begin
    eff_lanes    = capture ? live_lanes : snap_lanes;
    eff_en       = capture ? live_en    : snap_en;
    eff_bc_ok    = capture ? live_bc    : snap_bc;
    eff_hit_keep = capture ? live_pl    : snap_pl;
    eff_mc_mode  = capture ? live_mc    : snap_mc;
  end
endmodule

// File: rtl/eaf_cam_match.sv
module eaf_cam_match
  import eaf_pkg::*;
#(
  parameter int N_ENT = 8
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    take,
  input  logic                                    first,
  input  logic [IDX_W-1:0]                        cur_idx,
  input  logic [BYTE_W-1:0]                       rx_byte,
  input  logic [ADDR_BYTES-1:0][BYTE_W*N_ENT-1:0] lanes,
  output logic [N_ENT-1:0]                        match_now,
  output logic                                    bcast_now,
  output logic                                    mcast_now
);
  logic [BYTE_W*N_ENT-1:0] cur_lane;
  logic [N_ENT-1:0]        eq, match_q;
  logic                    bcast_q, mcast_q;

  always_comb begin
    cur_lane = '0;
    for (int k = 0; k < ADDR_BYTES; k++)
      if (cur_idx == IDX_W'(k)) cur_lane = lanes[k];
  end

  for (genvar n = 0; n < N_ENT; n++) begin : g_ent
    assign eq[n] = (rx_byte == cur_lane[n*BYTE_W +: BYTE_W]);
  end

  always_comb begin
    match_now = (first ? {N_ENT{1'b1}} : match_q) & eq;
    bcast_now = (first ? 1'b1 : bcast_q) & (&rx_byte);
    mcast_now = first ? rx_byte[0] : mcast_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_q <= '0;
      bcast_q <= 1'b0;
      mcast_q <= 1'b0;
    end else if (take) begin
      match_q <= match_now;
      bcast_q <= bcast_now;
      mcast_q <= mcast_now;
    end
  end
endmodule

// File: rtl/eaf_policy.sv
module eaf_policy
  import eaf_pkg::*;
#(
  parameter int N_ENT = 8
) (
  input  logic [N_ENT-1:0] match,
  input  logic [N_ENT-1:0] en,
  input  logic             is_bcast,
  input  logic             is_mcast,
  input  logic             bc_ok,
  input  logic             hit_keep,
  input  mc_mode_e         mc_mode,
  output logic             keep
);
  logic hit, table_keep;

  always_comb begin
    hit        = |(match & en);
    table_keep = hit_keep ? hit : ~hit;
    if (is_bcast) begin
      keep = bc_ok;
    end else if (is_mcast) begin
      case (mc_mode)
        MC_ACCEPT: keep = 1'b1;
        MC_TABLE:  keep = table_keep;
        default:   keep = 1'b0;
      endcase
    end else begin
      keep = table_keep;
    end
  end
endmodule

// File: rtl/eth_dst_filter.sv
module eth_dst_filter
  import eaf_pkg::*;
#(
  parameter int N_ENT = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [2:0]              cfg_addr,
  input  logic [BYTE_W*N_ENT-1:0] cfg_wdata,
  input  logic                    in_valid,
  input  logic                    in_sof,
  input  logic                    in_last,
  input  logic [7:0]              in_data,
  output logic                    dec_valid,
  output logic                    dec_accept
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ADDR_BYTES - 1);

  logic                                    in_addr_q;
  logic [IDX_W-1:0]                        idx_q, cur_idx;
  logic                                    take, first, addr_done, short_end;
  logic [ADDR_BYTES-1:0][BYTE_W*N_ENT-1:0] lanes;
  logic [N_ENT-1:0]                        en, match_now;
  logic                                    bc_ok, hit_keep, bcast_now, mcast_now, keep;
  mc_mode_e                                mc_mode;
  logic                                    dv_q, da_q;

  assign first     = in_valid & in_sof;
  assign take      = in_valid & (in_sof | in_addr_q);
  assign cur_idx   = first ? '0 : idx_q;
  assign addr_done = take & (cur_idx == LAST_IDX);
  assign short_end = take & in_last & (cur_idx < LAST_IDX);

  eaf_cfg_regs #(.N_ENT(N_ENT)) cfg_i (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .capture(first), .eff_lanes(lanes), .eff_en(en), .eff_bc_ok(bc_ok),
    .eff_hit_keep(hit_keep), .eff_mc_mode(mc_mode)
  );

  eaf_cam_match #(.N_ENT(N_ENT)) cam_i (
    .clk(clk), .rst_n(rst_n), .take(take), .first(first), .cur_idx(cur_idx),
    .rx_byte(in_data), .lanes(lanes), .match_now(match_now),
    .bcast_now(bcast_now), .mcast_now(mcast_now)
  );

  eaf_policy #(.N_ENT(N_ENT)) pol_i (
    .match(match_now), .en(en), .is_bcast(bcast_now), .is_mcast(mcast_now),
    .bc_ok(bc_ok), .hit_keep(hit_keep), .mc_mode(mc_mode), .keep(keep)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_addr_q <= 1'b0;
      idx_q     <= '0;
      dv_q      <= 1'b0;
      da_q      <= 1'b0;
    end else begin
      if (take) begin
        in_addr_q <= ~addr_done & ~in_last;
        idx_q     <= cur_idx + 1'b1;
      end
      dv_q <= addr_done | short_end;
      da_q <= addr_done & keep;
    end
  end

  assign dec_valid  = dv_q;
  assign dec_accept = da_q;
endmodule

// File: rtl/eth_dst_filter_chk.sv
module eth_dst_filter_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_sof,
  input logic in_last,
  input logic dec_valid,
  input logic dec_accept
);
  logic       ck_act;
  logic [2:0] ck_cnt, ck_pos;
  logic       ck_take;

  assign ck_take = in_valid && (in_sof || ck_act);
  assign ck_pos  = in_sof ? 3'd0 : ck_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ck_act <= 1'b0;
      ck_cnt <= 3'd0;
    end else if (ck_take) begin
      ck_act <= (ck_pos != 3'd5) && !in_last;
      ck_cnt <= ck_pos + 3'd1;
    end
  end

  // R7
  sixth_byte_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_take && ck_pos == 3'd5) |=> dec_valid);

  // R8
  short_frame_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_take && in_last && ck_pos < 3'd5) |=> (dec_valid && !dec_accept));

  // R7
  accept_needs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_accept |-> dec_valid);

  // R11
  idle_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !dec_valid);
endmodule

bind eth_dst_filter eth_dst_filter_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
  .in_last(in_last), .dec_valid(dec_valid), .dec_accept(dec_accept)
);

// File: tb/eth_dst_filter_tb_top.sv
`timescale 1ns/1ps
module eth_dst_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [63:0] cfg_wdata = '0;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_last = 1'b0;
  logic [7:0]  in_data = '0;
  logic        dec_valid, dec_accept;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  eth_dst_filter dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_sof(in_sof),
    .in_last(in_last), .in_data(in_data), .dec_valid(dec_valid),
    .dec_accept(dec_accept)
  );

  localparam logic [47:0] OWN  = 48'h02_11_22_33_44_55;
  localparam logic [47:0] GRP1 = 48'h01_00_5E_00_00_01;
  localparam logic [47:0] GRP2 = 48'h33_33_00_00_00_02;
  localparam logic [47:0] BCST = 48'hFF_FF_FF_FF_FF_FF;
  localparam logic [47:0] UNI2 = 48'h02_11_22_33_44_56;
  localparam logic [47:0] MC_X = 48'h01_80_C2_00_00_00;
  // control: en[7:0], bc bit 8, polarity bit 9, multicast mode [11:10]
  localparam logic [63:0] CTRL_TBL = 64'hB03;

  // {address, expected keep} under the table configuration
  localparam logic [48:0] VECS [0:8] = '{
    {OWN,  1'b1},                    // R1 own entry hits
    {UNI2, 1'b0},                    // R1 last byte differs
    {GRP1, 1'b1},                    // R5 table policy, enabled group
    {GRP2, 1'b0},                    // R2 disabled entry
    {BCST, 1'b1},                    // R4 broadcast bit set
    {MC_X, 1'b0},                    // R5 unknown group
    {48'h12_11_22_33_44_55, 1'b0},   // R1 first byte differs
    {48'h01_00_5E_00_00_02, 1'b0},   // R1 near-miss group
    {48'h00_00_00_00_00_00, 1'b0}    // R2 unprogrammed, disabled entries
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic load_table();
    logic [47:0] ents [3];
    ents[0] = OWN; ents[1] = GRP1; ents[2] = GRP2;
    for (int k = 0; k < 6; k++) begin
      logic [63:0] lane;
      lane = '0;
      for (int n = 0; n < 3; n++) lane[n*8 +: 8] = ents[n][47-8*k -: 8];
      wr(3'(k), lane);
    end
    wr(3'd6, CTRL_TBL);
  endtask

  // Sends a frame; reports {stray pulse, pulse at expected beat, verdict}.
  task automatic send(input logic [47:0] a, input int nb, input bit gap,
                      input int wr_at, input logic [63:0] wd,
                      output logic [2:0] res);
    int dec_at;
    dec_at = (nb < 6) ? nb - 1 : 5;
    res = 3'b000;
    for (int i = 0; i < nb; i++) begin
      in_valid = 1'b1;
      in_sof   = (i == 0);
      in_last  = (i == nb - 1);
      in_data  = (i < 6) ? a[47-8*i -: 8] : 8'hA5;
      if (i == wr_at) begin cfg_we = 1'b1; cfg_addr = 3'd6; cfg_wdata = wd; end
      @(posedge clk); #1;
      cfg_we = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_last = 1'b0;
      if (i == dec_at) begin
        res[1] = dec_valid; res[0] = dec_accept;
      end else if (dec_valid) res[2] = 1'b1;
      if (gap) begin
        @(posedge clk); #1;
        if (dec_valid) res[2] = 1'b1;
      end
    end
    @(posedge clk); #1;
    if (dec_valid) res[2] = 1'b1;
  endtask

  task automatic frame(input string req, input logic [47:0] a, input logic exp);
    logic [2:0] r;
    send(a, 8, 1'b0, -1, '0, r);
    check(req, {5'd0, r}, {5'd0, 2'b01, exp});
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [2:0] r;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    check("R10 outputs after reset", {6'd0, dec_valid, dec_accept}, 8'd0);
    frame("R10 default keeps unicast", OWN, 1'b1);
    frame("R10 default drops multicast", GRP1, 1'b0);
    frame("R10 default drops broadcast", BCST, 1'b0);

    load_table();
    for (int v = 0; v < 9; v++) begin
      send(VECS[v][48:1], 8, 1'b0, -1, '0, r);
      check($sformatf("R1/R2/R4/R5 table vector %0d", v), {5'd0, r},
            {5'd0, 2'b01, VECS[v][0]});
    end

    wr(3'd7, 64'hFFFF);
    frame("R1 slot 7 write ignored", OWN, 1'b1);

    wr(3'd6, 64'h901);
    frame("R3 hit discards", OWN, 1'b0);
    frame("R3 miss keeps", UNI2, 1'b1);
    frame("R3 table policy with miss keeps group", GRP1, 1'b1);

    wr(3'd6, 64'h703);
    frame("R5 mode 1 keeps unknown group", MC_X, 1'b1);
    wr(3'd6, 64'h303);
    frame("R5 mode 0 drops listed group", GRP1, 1'b0);
    frame("R5 mode 0 leaves unicast alone", OWN, 1'b1);
    wr(3'd6, 64'hF03);
    frame("R5 mode 3 drops", GRP1, 1'b0);

    wr(3'd6, 64'h400);
    frame("R4 broadcast bit clear drops", BCST, 1'b0);
    wr(3'd6, 64'h300);
    frame("R4 broadcast bit set keeps", BCST, 1'b1);

    wr(3'd6, 64'h500);
    frame("R6 promiscuous unicast", UNI2, 1'b1);
    frame("R6 promiscuous multicast", MC_X, 1'b1);
    frame("R6 promiscuous broadcast", BCST, 1'b1);

    wr(3'd6, CTRL_TBL);
    send(OWN, 3, 1'b0, -1, '0, r);
    check("R8 three-byte frame dropped", {5'd0, r}, 8'b010);
    send(OWN, 1, 1'b0, -1, '0, r);
    check("R8 one-byte frame dropped", {5'd0, r}, 8'b010);
    send(OWN, 6, 1'b0, -1, '0, r);
    check("R7 six-byte frame verdict", {5'd0, r}, 8'b011);
    send(OWN, 20, 1'b0, -1, '0, r);
    check("R7 long frame single pulse", {5'd0, r}, 8'b011);

    send(OWN, 8, 1'b1, -1, '0, r);
    check("R11 gaps keep verdict", {5'd0, r}, 8'b011);

    // stray bytes without a start beat
    r = 3'b000;
    for (int i = 0; i < 8; i++) begin
      in_valid = 1'b1; in_data = OWN[47-8*(i%6) -: 8];
      @(posedge clk); #1;
      in_valid = 1'b0;
      if (dec_valid) r[2] = 1'b1;
    end
    check("R7 stray bytes ignored", {5'd0, r}, 8'd0);

    send(OWN, 8, 1'b0, 2, 64'h200, r);
    check("R9 mid-frame write deferred", {5'd0, r}, 8'b011);
    frame("R9 write applies next frame", OWN, 1'b0);
    send(OWN, 8, 1'b0, 0, CTRL_TBL, r);
    check("R9 write on start beat deferred", {5'd0, r}, 8'b010);
    frame("R9 start-beat write applies next", OWN, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule